// File: doc/BRIEF.md
# Six-Valued Static Hazard Evaluator

This unit evaluates one logic gate in a six-valued algebra built for static hazard analysis. Each value is a three-point sequence over {0, 1, u}: the settled value before a change, the value while inputs are switching, and the settled value after. Two operand codes and an operation code go in. After one register stage, the unit returns the six-valued result, a flag that marks a static hazard, and an error flag for illegal codes.

The gate rule is applied separately at each of the three points, using three-valued logic. Whenever the outcome depends on u, the rule gives u. The resulting sequence is then mapped back to a code, so a glitch-prone output shows up directly as a hazard class.

A separate combinational path turns the old and new binary values of one signal into an operand code. A hazard analyser can use it to build stimulus for the next gate level.

Value codes (3 bits): 0 = steady 0 (000), 1 = steady 1 (111), 2 = rise (0u1), 3 = fall (1u0), 4 = 0-hazard (0u0), 5 = 1-hazard (1u1). Codes 6 and 7 are illegal. Operation codes (3 bits): 0 = AND, 1 = OR, 2 = NAND, 3 = NOR, 4 = NOT (uses opA only). Codes 5 to 7 are illegal.

Top module: `hz6_eval`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: AND is taken point-wise over the three sequence points. Any 0 gives 0, otherwise any u gives u, otherwise 1. Examples: AND(R,F)=0*, AND(1,R)=R, AND(1*,1*)=1*, AND(F,0*)=0*.
- R3: OR is taken point-wise. Any 1 gives 1, otherwise any u gives u, otherwise 0. Examples: OR(R,F)=1*, OR(0,F)=F, OR(0*,R)=R.
- R4: NAND and NOR are the point-wise inverse of AND and OR, with NOT(u)=u. Examples: NAND(R,F)=1*, NOR(R,F)=0*, NOR(0,R)=F.
- R5: NOT maps 0 to 1, 1 to 0, R to F, F to R, 0* to 1* and 1* to 0*.
- R6: Whenever outValid is 1, outHazard is 1 exactly when outVal is 4 (0u0) or 5 (1u1).
- R7: An illegal opcode, an illegal opA, or an illegal opB with any opcode other than NOT sets outError. In that case outVal is 0 and outHazard is 0. An illegal opB is ignored under NOT.
- R8: A request is accepted on a rising edge where inValid and inReady are both 1. Its result is on the outputs with outValid=1 from the next cycle. inReady equals (!outValid || outReady). While outReady is 0, the output holds its result.
- R9: buildCode is combinational. Equal old and new values give code 0 or 1 (the value itself). Old 0 and new 1 give 2 (R). Old 1 and new 0 give 3 (F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Unit can take a request |
| opA | input | 3 | First operand code |
| opB | input | 3 | Second operand code |
| opCode | input | 3 | Operation code |
| outReady | input | 1 | Consumer takes the result |
| outValid | output | 1 | Result valid |
| outVal | output | 3 | Six-valued result code |
| outHazard | output | 1 | Static hazard present in the result |
| outError | output | 1 | Illegal operand or opcode |
| buildOld | input | 1 | Signal value before the change |
| buildNew | input | 1 | Signal value after the change |
| buildCode | output | 3 | Operand code built from old and new values |

## Verification
Each request affects only the one result it produces, so a fault in the per-point rules or in the sequence-to-code mapping shows up at the next valid output, one cycle after the request is accepted. The test vectors include operands whose middle points are u, so that a dropped u or a wrong inversion turns a hazard class into a clean transition. A fault in the valid/ready state shows up as a lost, duplicated or changed result during a stall, and it can be seen within the first stalled cycle.

// File: rtl/hz6_pkg.sv
package hz6_pkg;
  localparam int CODE_W  = 3;
  localparam int OP_W    = 3;
  localparam int TRIT_W  = 2;
  localparam int SEQ_LEN = 3;
  localparam int P_PRE   = SEQ_LEN - 1;
  localparam int P_MID   = 1;
  localparam int P_POST  = 0;

  typedef logic [TRIT_W-1:0] trit_t;
  typedef logic [SEQ_LEN-1:0][TRIT_W-1:0] seq_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam trit_t T0 = 2'b00;
  localparam trit_t T1 = 2'b01;
  localparam trit_t TU = 2'b10;

  localparam code_t V_ZERO = 3'd0;
  localparam code_t V_ONE  = 3'd1;
  localparam code_t V_RISE = 3'd2;
  localparam code_t V_FALL = 3'd3;
  localparam code_t V_HZ0  = 3'd4;
  localparam code_t V_HZ1  = 3'd5;

  localparam logic [OP_W-1:0] OP_AND  = 3'd0;
  localparam logic [OP_W-1:0] OP_OR   = 3'd1;
  localparam logic [OP_W-1:0] OP_NAND = 3'd2;
  localparam logic [OP_W-1:0] OP_NOR  = 3'd3;
  localparam logic [OP_W-1:0] OP_NOT  = 3'd4;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

  function automatic logic codeLegal(input code_t c);
    return c <= V_HZ1;
  endfunction

  function automatic seq_t mkSeq(input trit_t pre, input trit_t mid, input trit_t post);
    seq_t s;
    s[P_PRE]  = pre;
    s[P_MID]  = mid;
    s[P_POST] = post;
    return s;
  endfunction

  function automatic seq_t decodeSeq(input code_t c);
    case (c)
      V_ONE:   return mkSeq(T1, T1, T1);
      V_RISE:  return mkSeq(T0, TU, T1);
      V_FALL:  return mkSeq(T1, TU, T0);
      V_HZ0:   return mkSeq(T0, TU, T0);
      V_HZ1:   return mkSeq(T1, TU, T1);
      default: return mkSeq(T0, T0, T0);
    endcase
  endfunction

  function automatic code_t encodeSeq(input seq_t s);
    if (s[P_PRE] == s[P_POST]) begin
      if (s[P_MID] == s[P_PRE]) return (s[P_PRE] == T1) ? V_ONE : V_ZERO;
      return (s[P_PRE] == T1) ? V_HZ1 : V_HZ0;
    end
    return (s[P_PRE] == T0) ? V_RISE : V_FALL;
  endfunction

  function automatic trit_t tritAnd(input trit_t a, input trit_t b);
    if (a == T0 || b == T0) return T0;
    if (a == TU || b == TU) return TU;
    return T1;
  endfunction

  function automatic trit_t tritOr(input trit_t a, input trit_t b);
    if (a == T1 || b == T1) return T1;
    if (a == TU || b == TU) return TU;
    return T0;
  endfunction

  function automatic trit_t tritNot(input trit_t a);
    if (a == TU) return TU;
    return (a == T1) ? T0 : T1;
  endfunction

  function automatic trit_t evalPos(input logic [OP_W-1:0] op, input trit_t a, input trit_t b);
    case (op)
      OP_AND:  return tritAnd(a, b);
      OP_OR:   return tritOr(a, b);
      OP_NAND: return tritNot(tritAnd(a, b));
      OP_NOR:  return tritNot(tritOr(a, b));
      OP_NOT:  return tritNot(a);
      default: return T0;
    endcase
  endfunction
endpackage

// File: rtl/hz6_datapath.sv
module hz6_datapath
  import hz6_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CODE_W-1:0] opA,
  input  logic [CODE_W-1:0] opB,
  input  logic [OP_W-1:0]   opCode,
  input  logic              buildOld,
  input  logic              buildNew,
  output logic [CODE_W-1:0] resVal,
  output logic              resHaz,
  output logic              resErr,
  output logic [CODE_W-1:0] buildCode
);
  seq_t seqA, seqB, resSeq, buildSeq;
  logic opOk, aOk, bOk, anyErr, seqHaz;
  code_t resCode;

  assign seqA = decodeSeq(opA);
  assign seqB = decodeSeq(opB);

  for (genvar p = 0; p < SEQ_LEN; p++) begin : g_pos
    assign resSeq[p] = evalPos(opCode, seqA[p], seqB[p]);
  end

  assign opOk   = (opCode <= OP_NOT);
  assign aOk    = codeLegal(opA);
  assign bOk    = codeLegal(opB) || (opCode == OP_NOT);
  assign anyErr = !(opOk && aOk && bOk);

  assign resCode = encodeSeq(resSeq);
  assign seqHaz  = (resSeq[P_PRE] == resSeq[P_POST]) && (resSeq[P_MID] == TU);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resVal <= V_ZERO;
      resHaz <= 1'b0;
      resErr <= 1'b0;
    end else if (strobe.load) begin
      resVal <= anyErr ? V_ZERO : resCode;
      resHaz <= !anyErr && seqHaz;
      resErr <= anyErr;
    end
  end

  always_comb begin
    buildSeq = mkSeq({1'b0, buildOld},
                     (buildOld != buildNew) ? TU : {1'b0, buildOld},
                     {1'b0, buildNew});
    buildCode = encodeSeq(buildSeq);
  end
endmodule

// File: rtl/hz6_ctrl.sv
module hz6_ctrl
  import hz6_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  assign inReady     = !outValid || outReady;
  assign strobe.load = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN)            outValid <= 1'b0;
    else if (strobe.load) outValid <= 1'b1;
    else if (outReady)    outValid <= 1'b0;
  end
endmodule

// File: rtl/hz6_eval.sv
module hz6_eval
  import hz6_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CODE_W-1:0] opA,
  input  logic [CODE_W-1:0] opB,
  input  logic [OP_W-1:0]   opCode,
  input  logic              outReady,
  output logic              outValid,
  output logic [CODE_W-1:0] outVal,
  output logic              outHazard,
  output logic              outError,
  input  logic              buildOld,
  input  logic              buildNew,
  output logic [CODE_W-1:0] buildCode
);
  ctrlStrobe_t strobe;

  hz6_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  hz6_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .opCode(opCode), .buildOld(buildOld), .buildNew(buildNew),
    .resVal(outVal), .resHaz(outHazard), .resErr(outError),
    .buildCode(buildCode)
  );
endmodule

// File: rtl/hz6_eval_chk.sv
module hz6_eval_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic [2:0] opA,
  input logic [2:0] opB,
  input logic [2:0] opCode,
  input logic       outReady,
  input logic       outValid,
  input logic [2:0] outVal,
  input logic       outHazard,
  input logic       outError,
  input logic       buildOld,
  input logic       buildNew,
  input logic [2:0] buildCode
);
  AST_LEGAL_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outVal <= 3'd5); // R2
  AST_HAZARD_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outHazard == (outVal == 3'd4 || outVal == 3'd5))); // R6
  AST_ERROR_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outError) |-> (outVal == 3'd0 && !outHazard)); // R7
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outVal) && $stable(outHazard) && $stable(outError))); // R8
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady); // R8
  AST_BUILD_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (buildOld == buildNew) |-> buildCode == {2'b00, buildOld}); // R9
  AST_BUILD_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (buildOld != buildNew) |-> buildCode == (buildNew ? 3'd2 : 3'd3)); // R9
endmodule

bind hz6_eval hz6_eval_chk chk_i (.*);

// File: tb/hz6_eval_tb_top.sv
module hz6_eval_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, outReady = 1'b1, buildOld = 1'b0, buildNew = 1'b0;
  logic [2:0] opA = '0, opB = '0, opCode = '0;
  logic inReady, outValid, outHazard, outError;
  logic [2:0] outVal, buildCode;
  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] v;
    logic       h;
    logic       e;
    string      tag;
  } exp_t;
  exp_t sbQ[$];

  always #10 clk = ~clk;

  hz6_eval dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .opCode(opCode), .outReady(outReady),
    .outValid(outValid), .outVal(outVal), .outHazard(outHazard),
    .outError(outError), .buildOld(buildOld), .buildNew(buildNew),
    .buildCode(buildCode)
  );

  // codes: 0 steady0, 1 steady1, 2 R, 3 F, 4 0*, 5 1*; ops: 0 AND 1 OR 2 NAND 3 NOR 4 NOT
  task automatic send(input logic [2:0] a, input logic [2:0] b, input logic [2:0] op,
                      input logic [2:0] ev, input logic eh, input logic ee, input string tag);
    exp_t item;
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b; opCode = op;
    item.v = ev; item.h = eh; item.e = ee; item.tag = tag;
    sbQ.push_back(item);
    while (!inReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic check1(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per completed output transfer
  always @(negedge clk) begin
    exp_t e;
    if (rstN && outValid && outReady) begin
      checks++;
      if (sbQ.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected output actual=%0d expected=none", outVal);
      end else begin
        e = sbQ.pop_front();
        if (outVal !== e.v || outHazard !== e.h || outError !== e.e) begin
          errors++;
          $display("FAIL %s actual=val%0d haz%0b err%0b expected=val%0d haz%0b err%0b",
                   e.tag, outVal, outHazard, outError, e.v, e.h, e.e);
        end
      end
    end
  end

  task automatic checkBuild(input logic o, input logic n, input logic [2:0] ev);
    buildOld = o; buildNew = n;
    #1;
    check1(buildCode == ev, "R9 build", buildCode, ev);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check1(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check1(inReady == 1'b1, "R1 inReady after reset", inReady, 1);

    // R2 AND
    send(3'd2, 3'd3, 3'd0, 3'd4, 1'b1, 1'b0, "R2 AND(R,F)");
    send(3'd1, 3'd2, 3'd0, 3'd2, 1'b0, 1'b0, "R2 AND(1,R)");
    send(3'd2, 3'd2, 3'd0, 3'd2, 1'b0, 1'b0, "R2 AND(R,R)");
    send(3'd5, 3'd5, 3'd0, 3'd5, 1'b1, 1'b0, "R2 AND(1*,1*)");
    send(3'd0, 3'd5, 3'd0, 3'd0, 1'b0, 1'b0, "R2 AND(0,1*)");
    send(3'd3, 3'd4, 3'd0, 3'd4, 1'b1, 1'b0, "R2 AND(F,0*)");
    // R3 OR
    send(3'd2, 3'd3, 3'd1, 3'd5, 1'b1, 1'b0, "R3 OR(R,F)");
    send(3'd0, 3'd3, 3'd1, 3'd3, 1'b0, 1'b0, "R3 OR(0,F)");
    send(3'd1, 3'd4, 3'd1, 3'd1, 1'b0, 1'b0, "R3 OR(1,0*)");
    send(3'd4, 3'd2, 3'd1, 3'd2, 1'b0, 1'b0, "R3 OR(0*,R)");
    // R4 NAND / NOR
    send(3'd2, 3'd3, 3'd2, 3'd5, 1'b1, 1'b0, "R4 NAND(R,F)");
    send(3'd1, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, "R4 NAND(1,1)");
    send(3'd0, 3'd0, 3'd3, 3'd1, 1'b0, 1'b0, "R4 NOR(0,0)");
    send(3'd2, 3'd3, 3'd3, 3'd4, 1'b1, 1'b0, "R4 NOR(R,F)");
    send(3'd0, 3'd2, 3'd3, 3'd3, 1'b0, 1'b0, "R4 NOR(0,R)");
    // R5 NOT
    send(3'd2, 3'd0, 3'd4, 3'd3, 1'b0, 1'b0, "R5 NOT(R)");
    send(3'd3, 3'd0, 3'd4, 3'd2, 1'b0, 1'b0, "R5 NOT(F)");
    send(3'd4, 3'd0, 3'd4, 3'd5, 1'b1, 1'b0, "R5 NOT(0*)");
    send(3'd5, 3'd0, 3'd4, 3'd4, 1'b1, 1'b0, "R5 NOT(1*)");
    send(3'd0, 3'd0, 3'd4, 3'd1, 1'b0, 1'b0, "R5 NOT(0)");
    send(3'd1, 3'd0, 3'd4, 3'd0, 1'b0, 1'b0, "R5 NOT(1)");
    // R7 illegal codes
    send(3'd6, 3'd1, 3'd0, 3'd0, 1'b0, 1'b1, "R7 AND illegal opA");
    send(3'd1, 3'd7, 3'd1, 3'd0, 1'b0, 1'b1, "R7 OR illegal opB");
    send(3'd2, 3'd3, 3'd5, 3'd0, 1'b0, 1'b1, "R7 illegal opcode");
    send(3'd2, 3'd7, 3'd4, 3'd3, 1'b0, 1'b0, "R7 NOT ignores opB");
    send(3'd4, 3'd5, 3'd0, 3'd4, 1'b1, 1'b0, "R6 hazard after error");
    idle();
    @(negedge clk);
    check1(sbQ.size() == 0, "R8 queue drained", sbQ.size(), 0);

    // R8 stall: result held, input blocked
    @(posedge clk); #2 outReady = 1'b0;
    send(3'd2, 3'd3, 3'd1, 3'd5, 1'b1, 1'b0, "R8 stalled OR(R,F)");
    idle();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check1(outValid == 1'b1, "R8 valid held", outValid, 1);
      check1(inReady == 1'b0, "R8 ready low", inReady, 0);
      check1(outVal == 3'd5, "R8 value held", outVal, 5);
    end
    @(posedge clk); #2 outReady = 1'b1;
    idle();
    @(negedge clk);
    check1(outValid == 1'b0, "R8 drained after stall", outValid, 0);
    check1(sbQ.size() == 0, "R8 stalled item delivered", sbQ.size(), 0);

    // R9 operand builder
    checkBuild(1'b0, 1'b0, 3'd0);
    checkBuild(1'b1, 1'b1, 3'd1);
    checkBuild(1'b0, 1'b1, 3'd2);
    checkBuild(1'b1, 1'b0, 3'd3);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule